// File: doc/BRIEF.md
# Port-Group Egress Mask Resolver

This block decides which output ports of a Layer 2 Ethernet switch receive one frame. It keeps a table of port-group bitmasks in registers. For every frame descriptor it reads three entries from that table and ANDs them together to form the egress set:

- a destination entry, which says where the frame should go;
- an aggregation entry, which keeps one link-aggregation flow on a single member link;
- a source entry, which says which ports the ingress port may forward to.

The destination entry comes from the MAC-table result when the lookup hit. On a miss it comes from one of three programmable flood-index registers, chosen by the frame class. The output mask has one bit for each physical port. One further bit, placed just above the last physical port, stands for the internal CPU queue module.

Software fills the table and the flood registers through a single write port. Frame descriptors enter through a valid/ready handshake, pass through two register stages and leave as a mask on a second valid/ready handshake.

With the default parameters there are 11 physical ports, so the mask is 12 bits wide. The table has 91 entries:

| Table index | Entry kind | How it is selected |
|---|---|---|
| 0 to 63 | destination | destination index |
| 64 to 79 | aggregation | 64 plus the aggregation code |
| 80 to 90 | source | 80 plus the ingress port |

Top module: `pgmask_resolver`

## Requirements
- R1: After reset, every table entry and every flood register holds zero, `rsp_valid` is low, and any frame resolves to an all-zero mask until software writes the table.
- R2: When `req_hit` is 1, the destination entry read is the one at table index `req_dest_idx`.
- R3: When `req_hit` is 0, the destination index comes from a flood register chosen by `req_class`: class 0 (unicast) uses the register at `cfg_addr` 0x80, class 1 (multicast) uses 0x81, and classes 2 and 3 (broadcast) use 0x82. A flood register takes `cfg_wdata[5:0]`. The register value in force when the descriptor is accepted is the one used.
- R4: The aggregation entry read is the one at table index 64 + `req_lac`.
- R5: The source entry read is the one at table index 80 + `req_src`. If `req_src` is 11 or more, the mask is all zero.
- R6: The output mask is the bitwise AND of the destination, aggregation and source entries. Bit 11 is the CPU queue module and is carried through like any port bit. A table entry is written by `cfg_we` with `cfg_addr` equal to the table index (0 to 90), taking `cfg_wdata`.
- R7: The bit of the ingress port is always clear in the output mask.
- R8: A descriptor accepted on clock edge E, with `rsp_ready` high, appears with `rsp_valid` high after edge E+1. Back-to-back descriptors stream at one per cycle.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_mask` hold steady. `req_ready` drops once both stages are full. Responses come out in acceptance order, and none are lost or duplicated.
- R10: A table write that lands on the same clock edge as the table read for a descriptor does not affect that descriptor's mask. The next descriptor sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Write address: a table index, or 0x80 to 0x82 for the flood registers |
| cfg_wdata | input | 12 | Write data: a mask for a table entry, or an index in bits [5:0] for a flood register |
| req_valid | input | 1 | Frame descriptor valid |
| req_ready | output | 1 | Descriptor accepted when high together with `req_valid` |
| req_hit | input | 1 | MAC-table lookup hit |
| req_dest_idx | input | 6 | Destination index from the matching MAC-table entry |
| req_class | input | 2 | Frame class: 0 unicast, 1 multicast, 2 or 3 broadcast |
| req_lac | input | 4 | Link-aggregation code |
| req_src | input | 4 | Ingress port number |
| rsp_valid | output | 1 | Egress mask valid |
| rsp_ready | input | 1 | Downstream takes the mask when high together with `rsp_valid` |
| rsp_mask | output | 12 | Egress port mask; bit 11 is the CPU queue module |

## Verification
Directed frames use a table of one-hot unicast entries, a CPU-only entry and patterned flood entries. This lets a wrong index pick show up as a distinct mask for a hit, for each flood class, for a chosen aggregation code and for a restricted source entry. Frames that enter on a port inside their own destination set separate the ingress clearing from the AND itself. Out-of-range ingress ports 11 and 12 expose a source read that runs past the table. A write timed onto the read edge tells the old entry value from the new one. A held-off downstream with three queued frames tells stable holding and in-order release apart from dropping or duplication. Random tables and descriptors then run with a steady ready and with a random one, and every mask is compared against a bench model of the triple AND.

// File: rtl/pgm_pkg.sv
// Package: shared definitions for the port-group egress mask resolver.
// Assumes: frame class is a 2-bit code, and code 3 is handled as broadcast.
package pgm_pkg;

    typedef enum logic [1:0] {
        CLS_UCAST  = 2'd0,
        CLS_MCAST  = 2'd1,
        CLS_BCAST  = 2'd2,
        CLS_BCAST2 = 2'd3
    } frame_class_e;

    // Flood register selectors (low address bits of a flood write).
    localparam logic [1:0] FLOOD_SEL_UC = 2'd0;
    localparam logic [1:0] FLOOD_SEL_MC = 2'd1;
    localparam logic [1:0] FLOOD_SEL_BC = 2'd2;

endpackage

// File: rtl/pgm_table.sv
// Module: pgm_table
// Register file of port-group masks. It has one synchronous write port and
// RD_PORTS combinational read ports.
// Assumes: a read index at or above ENTRIES returns zero, and a read on the
// same edge as a write sees the value held before that edge.
module pgm_table #(
    parameter int ENTRIES  = 91,
    parameter int IDX_W    = 7,
    parameter int DATA_W   = 12,
    parameter int RD_PORTS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx  [RD_PORTS],
    output logic [DATA_W-1:0] rd_data [RD_PORTS]
);

    logic [DATA_W-1:0] mem [ENTRIES];

    // Clear every entry on reset; otherwise update the addressed entry.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                mem[e] <= wr_data;
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        // Read port p: the stored entry, or zero when the index is out of range.
        always_comb begin
            rd_data[p] = '0;
            if (rd_idx[p] < IDX_W'(ENTRIES)) begin
                rd_data[p] = mem[rd_idx[p]];
            end
        end
    end

endmodule

// File: rtl/pgm_flood_sel.sv
// Module: pgm_flood_sel
// Holds the three flood-index registers and picks the destination index:
// the MAC-table index on a hit, or the flood index for the class on a miss.
// Assumes: a write with selector 3 is dropped, and class 3 floods as broadcast.
module pgm_flood_sel
    import pgm_pkg::*;
#(
    parameter int DEST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DEST_W-1:0] wr_idx,
    input  logic              hit,
    input  logic [DEST_W-1:0] hit_idx,
    input  frame_class_e      cls,
    output logic [DEST_W-1:0] dest_idx
);

    logic [DEST_W-1:0] uc_idx;
    logic [DEST_W-1:0] mc_idx;
    logic [DEST_W-1:0] bc_idx;

    // Load the flood register named by the write selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uc_idx <= '0;
            mc_idx <= '0;
            bc_idx <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                FLOOD_SEL_UC: uc_idx <= wr_idx;
                FLOOD_SEL_MC: mc_idx <= wr_idx;
                FLOOD_SEL_BC: bc_idx <= wr_idx;
                default: ;
            endcase
        end
    end

    // Choose the hit index, or the flood index for the class on a miss.
    always_comb begin
        if (hit) begin
            dest_idx = hit_idx;
        end else begin
            case (cls)
                CLS_UCAST: dest_idx = uc_idx;
                CLS_MCAST: dest_idx = mc_idx;
                default:   dest_idx = bc_idx;
            endcase
        end
    end

endmodule

// File: rtl/pgm_combine.sv
// Module: pgm_combine
// ANDs N_IN port-group masks and clears the ingress port bit.
// Assumes: src_ok is low for an ingress port that has no source entry;
// the result is then forced to zero.
module pgm_combine #(
    parameter int MASK_W = 12,
    parameter int PORT_W = 4,
    parameter int N_IN   = 3
) (
    input  logic [MASK_W-1:0] masks [N_IN],
    input  logic [PORT_W-1:0] src,
    input  logic              src_ok,
    output logic [MASK_W-1:0] result
);

    logic [MASK_W-1:0] acc [N_IN+1];
    logic [MASK_W-1:0] ingress_bit;

    assign acc[0] = '1;

    for (genvar g = 0; g < N_IN; g++) begin : g_and
        assign acc[g+1] = acc[g] & masks[g];
    end

    // Build the ingress bit, then remove it from the ANDed set.
    always_comb begin
        ingress_bit = MASK_W'(1) << src;
        result      = src_ok ? (acc[N_IN] & ~ingress_bit) : '0;
    end

endmodule

// File: rtl/pgmask_resolver.sv
// Module: pgmask_resolver (top)
// Two-stage egress mask resolver. Stage 1 registers the resolved destination
// index, the aggregation code and the ingress port. Stage 2 reads the table
// three times, ANDs the entries and registers the mask.
// Assumes: CFG_ADDR_W > table index width; the address MSB selects the flood
// registers.
module pgmask_resolver
    import pgm_pkg::*;
#(
    parameter  int NUM_PORTS  = 11,
    parameter  int LAC_W      = 4,
    parameter  int DEST_W     = 6,
    parameter  int PORT_W     = 4,
    parameter  int CFG_ADDR_W = 8,
    localparam int MASK_W     = NUM_PORTS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [MASK_W-1:0]     cfg_wdata,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_hit,
    input  logic [DEST_W-1:0]     req_dest_idx,
    input  logic [1:0]            req_class,
    input  logic [LAC_W-1:0]      req_lac,
    input  logic [PORT_W-1:0]     req_src,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [MASK_W-1:0]     rsp_mask
);

    localparam int DEST_N    = 1 << DEST_W;
    localparam int AGGR_N    = 1 << LAC_W;
    localparam int AGGR_BASE = DEST_N;
    localparam int SRC_BASE  = AGGR_BASE + AGGR_N;
    localparam int TBL_N     = SRC_BASE + NUM_PORTS;
    localparam int TBL_IDX_W = $clog2(TBL_N);
    localparam int N_LOOKUP  = 3;

    // Stage 1 state
    logic              s1_valid;
    logic [DEST_W-1:0] s1_dest;
    logic [LAC_W-1:0]  s1_lac;
    logic [PORT_W-1:0] s1_src;
    logic              s1_src_ok;

    // Stage 2 side state
    logic [PORT_W-1:0] s2_src;
    logic              s2_src_ok;

    logic              adv1;
    logic              adv2;
    logic [DEST_W-1:0] sel_dest;
    logic              tbl_we;
    logic              flood_we;
    logic [TBL_IDX_W-1:0] rd_idx  [N_LOOKUP];
    logic [MASK_W-1:0]    rd_data [N_LOOKUP];
    logic [MASK_W-1:0]    comb_mask;

    // Handshake: each stage moves when the stage after it can take data.
    always_comb begin
        adv2      = !rsp_valid || rsp_ready;
        adv1      = !s1_valid || adv2;
        req_ready = adv1;
    end

    // Decode configuration writes into table and flood register strobes.
    always_comb begin
        flood_we = cfg_we && cfg_addr[CFG_ADDR_W-1];
        tbl_we   = cfg_we && (cfg_addr < CFG_ADDR_W'(TBL_N));
    end

    pgm_flood_sel #(
        .DEST_W (DEST_W)
    ) u_flood (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (flood_we),
        .wr_sel   (cfg_addr[1:0]),
        .wr_idx   (cfg_wdata[DEST_W-1:0]),
        .hit      (req_hit),
        .hit_idx  (req_dest_idx),
        .cls      (frame_class_e'(req_class)),
        .dest_idx (sel_dest)
    );

    // Stage 1: capture the resolved indices of an accepted descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_dest   <= '0;
            s1_lac    <= '0;
            s1_src    <= '0;
            s1_src_ok <= 1'b0;
        end else if (adv1) begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_dest   <= sel_dest;
                s1_lac    <= req_lac;
                s1_src    <= req_src;
                s1_src_ok <= (req_src < PORT_W'(NUM_PORTS));
            end
        end
    end

    // Table read addresses for the three lookups.
    always_comb begin
        rd_idx[0] = TBL_IDX_W'(s1_dest);
        rd_idx[1] = TBL_IDX_W'(AGGR_BASE) + TBL_IDX_W'(s1_lac);
        rd_idx[2] = TBL_IDX_W'(SRC_BASE) + TBL_IDX_W'(s1_src);
    end

    pgm_table #(
        .ENTRIES  (TBL_N),
        .IDX_W    (TBL_IDX_W),
        .DATA_W   (MASK_W),
        .RD_PORTS (N_LOOKUP)
    ) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (cfg_addr[TBL_IDX_W-1:0]),
        .wr_data (cfg_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    pgm_combine #(
        .MASK_W (MASK_W),
        .PORT_W (PORT_W),
        .N_IN   (N_LOOKUP)
    ) u_comb (
        .masks  (rd_data),
        .src    (s1_src),
        .src_ok (s1_src_ok),
        .result (comb_mask)
    );

    // Stage 2: register the final mask when the output slot is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_mask  <= '0;
            s2_src    <= '0;
            s2_src_ok <= 1'b0;
        end else if (adv2) begin
            rsp_valid <= s1_valid;
            if (s1_valid) begin
                rsp_mask  <= comb_mask;
                s2_src    <= s1_src;
                s2_src_ok <= s1_src_ok;
            end
        end
    end

endmodule

// File: rtl/pgmask_resolver_chk.sv
// Module: pgmask_resolver_chk
// Assertion checker bound to pgmask_resolver. It watches the handshakes,
// the output mask and the ingress port that travels with each result.
module pgmask_resolver_chk #(
    parameter int NUM_PORTS = 11,
    parameter int PORT_W    = 4,
    parameter int MASK_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [MASK_W-1:0] rsp_mask,
    input logic              s1_valid,
    input logic [PORT_W-1:0] s2_src,
    input logic              s2_src_ok
);

    logic rst_q_n;

    // Remember the reset level of the previous cycle.
    always_ff @(posedge clk) begin
        rst_q_n <= rst_n;
    end

    // R1: on the first edge out of reset, no response is pending.
    always @(posedge clk) begin
        if (!rst_q_n && rst_n) begin
            p_idle_after_reset_r1: assert (!rsp_valid)
                else $error("rsp_valid set right after reset");
        end
    end

    p_bad_src_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !s2_src_ok) |-> (rsp_mask == '0));

    p_ingress_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && s2_src_ok) |-> (rsp_mask[s2_src] == 1'b0));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) ##1 rsp_ready |=> rsp_valid);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask)));

    p_full_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind pgmask_resolver pgmask_resolver_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .MASK_W    (MASK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_mask  (rsp_mask),
    .s1_valid  (s1_valid),
    .s2_src    (s2_src),
    .s2_src_ok (s2_src_ok)
);

// File: tb/pgmask_resolver_tb.sv
// Bench for pgmask_resolver: directed corner cases followed by seeded random
// traffic, checked against a bench model of the triple-AND lookup.
module pgmask_resolver_tb;

    localparam int NP  = 11;
    localparam int MW  = NP + 1;
    localparam int TBN = 91;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [MW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_hit = 1'b0;
    logic [5:0]    req_dest_idx = '0;
    logic [1:0]    req_class = '0;
    logic [3:0]    req_lac = '0;
    logic [3:0]    req_src = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [MW-1:0] rsp_mask;

    pgmask_resolver u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_hit      (req_hit),
        .req_dest_idx (req_dest_idx),
        .req_class    (req_class),
        .req_lac      (req_lac),
        .req_src      (req_src),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_mask     (rsp_mask)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [MW-1:0] mask;
        int            acc_cyc;
        bit            lat;
        string         tag;
    } exp_t;

    logic [MW-1:0] m_tbl [TBN];
    logic [5:0]    m_fl [3];
    exp_t          q [$];
    int            checks = 0;
    int            fails = 0;
    int            cyc = 0;
    bit            rand_ready = 1'b0;

    always @(posedge clk) cyc++;

    function automatic logic [MW-1:0] model(bit hit, logic [5:0] di, logic [1:0] cls,
                                            logic [3:0] lac, logic [3:0] src);
        int d;
        logic [MW-1:0] m;
        if (src >= NP) return '0;
        d = hit ? int'(di) : int'(m_fl[(cls == 2'd3) ? 2 : int'(cls)]);
        m = m_tbl[d] & m_tbl[64 + int'(lac)] & m_tbl[80 + int'(src)];
        m[src] = 1'b0;
        return m;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [MW-1:0] act, logic [MW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_wr(int addr, int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = addr[7:0];
        cfg_wdata = data[MW-1:0];
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (addr < TBN) m_tbl[addr] = data[MW-1:0];
        else if (addr >= 128 && addr <= 130) m_fl[addr-128] = data[5:0];
    endtask

    task automatic send(bit hit, int di, int cls, int lac, int src, bit lat, string tag);
        exp_t e;
        bit   acc = 1'b0;
        @(negedge clk);
        req_valid    = 1'b1;
        req_hit      = hit;
        req_dest_idx = di[5:0];
        req_class    = cls[1:0];
        req_lac      = lac[3:0];
        req_src      = src[3:0];
        while (!acc) begin
            #1;
            if (req_ready) acc = 1'b1;
            else @(negedge clk);
        end
        e.mask    = model(hit, di[5:0], cls[1:0], lac[3:0], src[3:0]);
        e.acc_cyc = cyc;
        e.lat     = lat;
        e.tag     = tag;
        q.push_back(e);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // Response monitor: pop the oldest expected mask on each handshake.
    always @(negedge clk) begin
        exp_t e;
        if (rand_ready) rsp_ready = ($urandom % 4) != 0;
        #1;
        if (rst_n && rsp_valid && rsp_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R9", "response with none pending", rsp_mask, '0);
            end else begin
                e = q.pop_front();
                check(rsp_mask == e.mask, e.tag, "egress mask", rsp_mask, e.mask);
                if (e.lat)
                    check((cyc - e.acc_cyc) == 2, "R8", "latency in cycles",
                          MW'(cyc - e.acc_cyc), MW'(2));
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < 60 && q.size() != 0; i++) @(negedge clk);
        check(q.size() == 0, "R9", "all responses delivered", MW'(q.size()), '0);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [MW-1:0] held;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < TBN; i++) m_tbl[i] = '0;
        for (int i = 0; i < 3; i++) m_fl[i] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", MW'(rsp_valid), '0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", MW'(req_ready), MW'(1));
        send(1'b1, 5, 0, 0, 0, 1'b1, "R1");
        send(1'b0, 0, 2, 3, 4, 1'b1, "R1");
        drain();

        // Directed table: one-hot unicast entries, CPU entry, flood patterns.
        for (int i = 0; i < NP; i++) cfg_wr(i, 1 << i);
        cfg_wr(59, 12'h800);
        cfg_wr(60, 12'hFFF);
        cfg_wr(61, 12'h7FF);
        cfg_wr(62, 12'h555);
        cfg_wr(63, 12'hAAA);
        for (int i = 64; i < TBN; i++) cfg_wr(i, 12'hFFF);
        cfg_wr(128, 60);
        cfg_wr(129, 61);
        cfg_wr(130, 62);

        send(1'b1, 3, 0, 0, 0, 1'b1, "R2");
        send(1'b1, 59, 1, 0, 2, 1'b1, "R2");
        send(1'b0, 9, 0, 0, 4, 1'b1, "R3");
        send(1'b0, 9, 1, 0, 0, 1'b1, "R3");
        send(1'b0, 9, 2, 0, 1, 1'b1, "R3");
        send(1'b0, 9, 3, 0, 0, 1'b1, "R3");
        drain();
        cfg_wr(64 + 7, 12'h00F);
        send(1'b0, 0, 0, 7, 0, 1'b1, "R4");
        send(1'b0, 0, 0, 6, 0, 1'b1, "R4");
        cfg_wr(80 + 2, 12'h003);
        send(1'b1, 60, 0, 0, 2, 1'b1, "R5");
        send(1'b1, 60, 0, 0, 11, 1'b1, "R5");
        send(1'b1, 60, 0, 0, 12, 1'b1, "R5");
        send(1'b1, 60, 0, 0, 5, 1'b1, "R6");
        send(1'b1, 59, 0, 0, 10, 1'b1, "R6");
        send(1'b1, 3, 0, 0, 3, 1'b1, "R7");
        send(1'b0, 0, 0, 0, 9, 1'b1, "R7");
        drain();

        // R10: the write lands on the read edge of the first frame.
        fork
            send(1'b1, 60, 0, 5, 0, 1'b1, "R10");
            begin
                @(negedge clk);
                cfg_wr(64 + 5, 12'h003);
            end
        join
        send(1'b1, 60, 0, 5, 0, 1'b1, "R10");
        drain();

        // R9: hold off the output with three frames queued.
        @(negedge clk);
        rsp_ready = 1'b0;
        fork
            begin
                send(1'b1, 60, 0, 0, 1, 1'b0, "R9");
                send(1'b1, 61, 0, 0, 2, 1'b0, "R9");
                send(1'b0, 0, 2, 0, 3, 1'b0, "R9");
            end
            begin
                repeat (5) @(negedge clk);
                #2;
                check(req_ready == 1'b0, "R9", "req_ready with both stages full",
                      MW'(req_ready), '0);
                check(rsp_valid == 1'b1, "R9", "rsp_valid while stalled", MW'(rsp_valid), MW'(1));
                held = rsp_mask;
                check(held == q[0].mask, "R9", "held mask is the oldest frame", held, q[0].mask);
                repeat (3) begin
                    @(negedge clk);
                    #2;
                    check(rsp_valid && rsp_mask == held, "R9", "mask stable during stall",
                          rsp_mask, held);
                end
                @(negedge clk);
                rsp_ready = 1'b1;
            end
        join
        drain();

        // Random table and flood registers.
        for (int i = 0; i < TBN; i++) cfg_wr(i, int'(($urandom | $urandom) & 32'hFFF));
        for (int k = 0; k < 3; k++) cfg_wr(128 + k, int'($urandom % 64));

        for (int n = 0; n < 300; n++)
            send(1'(($urandom % 2)), int'($urandom % 64), int'($urandom % 4),
                 int'($urandom % 16), int'($urandom % 13), 1'b1, "R6");
        drain();

        rand_ready = 1'b1;
        for (int n = 0; n < 300; n++)
            send(1'(($urandom % 2)), int'($urandom % 64), int'($urandom % 4),
                 int'($urandom % 16), int'($urandom % 13), 1'b0, "R9");
        drain();
        rand_ready = 1'b0;
        @(negedge clk);
        rsp_ready = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule